// File: doc/BRIEF.md
# Keyboard Controller Host Command Decoder

This block holds the host-facing register logic of a PC-style keyboard controller. The host uses two byte-wide ports, a command port and a data port. Each write arrives as one cycle with `wr_en` high, and `wr_is_cmd` selects the port. The block holds a mode byte, a status byte and an output-port byte. It also holds a latch that records which command is waiting for a data byte.

A command byte takes effect in one of three ways. Some commands act at once: they change a mode or output-port bit, or they push a reply byte onto the keyboard-side reply path. Some commands only latch their code, and the next data-port byte is then routed to the register or path that the code names. Any command whose high nibble is all ones is a pulse request, and it resets the system when its bit 0 is low.

Every effect is registered. A write seen on clock edge k shows at the outputs after edge k. Byte pushes and reset requests are one-cycle pulses, each with a byte beside it. The devices that sit behind the reply paths are outside this block.

Top module: `ps2_host_cmd`

## Requirements
- R1: After reset, `status_o` is 0x18, `a20_o` is 1 and `xlate_o` is 0. The mode byte is 0x03 and the output-port byte is 0x03, and reading them back with commands 0x20 and 0xD0 shows these values.
- R2: Commands 0x60, 0xD1, 0xD2, 0xD3 and 0xD4 latch their code. The next data-port byte then goes to a different place for each code: 0x60 writes the mode byte, 0xD1 writes the output-port byte, 0xD2 pushes the byte on the keyboard reply path, 0xD3 pushes it on the auxiliary reply path, and 0xD4 sends it to the mouse device. The latch clears after that one data byte.
- R3: A data-port byte written while no command is latched is sent to the keyboard device (`kdev_valid` with the byte on `kdev_byte`).
- R4: Command 0x20 pushes the mode byte on the keyboard reply path. Command 0xD0 pushes the output-port byte on the same path.
- R5: Command 0xAA sets `status_o` bit 2 and pushes 0x55. Commands 0xA9, 0xAB and 0xC0 each push 0x00. All of these pushes use the keyboard reply path.
- R6: Command 0xA7 sets mode bit 5 and command 0xA8 clears it. Command 0xAD sets mode bit 4 and command 0xAE clears it.
- R7: Command 0xDF sets `a20_o` and output-port bit 1. Command 0xDD clears both.
- R8: A command in the range 0xF0 to 0xFF with bit 0 at 0 gives a one-cycle `sysrst_o` pulse. A command in that range with bit 0 at 1 does nothing.
- R9: A data byte written to the output port drives `a20_o` from its bit 1. If its bit 0 is 0, the same write gives a one-cycle `sysrst_o` pulse.
- R10: A data byte written to the mode register drives `xlate_o` from its bit 6.
- R11: A command code with no defined meaning changes no state and produces no output. A command that does not latch leaves an already latched code in place.
- R12: Each effect of a write appears in the cycle after the edge that takes the write. Only one of the push outputs (`kq_valid`, `aq_valid`, `kdev_valid`, `mdev_valid`) is high in any cycle, and no output pulses in a cycle that follows no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Host write strobe, one cycle per byte |
| wr_is_cmd | input | 1 | 1 selects the command port, 0 selects the data port |
| wr_byte | input | 8 | Byte written by the host |
| status_o | output | 8 | Status byte |
| a20_o | output | 1 | Address line 20 gate |
| xlate_o | output | 1 | Scan-code translation enable for the keyboard side |
| sysrst_o | output | 1 | System reset request, one-cycle pulse |
| kq_valid | output | 1 | Push onto the keyboard reply path |
| kq_byte | output | 8 | Byte pushed onto the keyboard reply path |
| aq_valid | output | 1 | Push onto the auxiliary reply path |
| aq_byte | output | 8 | Byte pushed onto the auxiliary reply path |
| kdev_valid | output | 1 | Byte sent to the keyboard device |
| kdev_byte | output | 8 | Byte sent to the keyboard device |
| mdev_valid | output | 1 | Byte sent to the mouse device |
| mdev_byte | output | 8 | Byte sent to the mouse device |

## Verification
One output-port write can move the A20 gate and request a system reset in the same cycle. The bench provokes this with bytes that clear bit 0 and bit 1 together, and with bytes that clear only one of them. It then compares `a20_o` and `sysrst_o` on that same cycle against a behavioural model. A latched command and an immediate command can also meet: a non-latching command is issued between a latching command and its data byte. The bench then checks that the data byte still goes to the latched target, and that the immediate command still has its own effect.

// File: rtl/ps2_host_cmd.sv
module ps2_host_cmd #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_is_cmd,
  input  logic [BW-1:0] wr_byte,
  output logic [BW-1:0] status_o,
  output logic          a20_o,
  output logic          xlate_o,
  output logic          sysrst_o,
  output logic          kq_valid,
  output logic [BW-1:0] kq_byte,
  output logic          aq_valid,
  output logic [BW-1:0] aq_byte,
  output logic          kdev_valid,
  output logic [BW-1:0] kdev_byte,
  output logic          mdev_valid,
  output logic [BW-1:0] mdev_byte
);
  localparam logic [BW-1:0] MODE_INIT = BW'(8'h03);
  localparam logic [BW-1:0] STAT_INIT = BW'(8'h18);
  localparam logic [BW-1:0] PORT_INIT = BW'(8'h03);
  localparam logic [BW-1:0] IDLE      = '0;

  logic [BW-1:0] mode_q, stat_q, port_q, latch_q;

  wire cmd_wr  = wr_en &  wr_is_cmd;
  wire data_wr = wr_en & ~wr_is_cmd;
  wire pulse_range = (wr_byte[7:4] == 4'hF);

  assign status_o = stat_q;
  assign a20_o    = port_q[1];
  assign xlate_o  = mode_q[6];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= MODE_INIT;
      stat_q     <= STAT_INIT;
      port_q     <= PORT_INIT;
      latch_q    <= IDLE;
      sysrst_o   <= 1'b0;
      kq_valid   <= 1'b0;
      kq_byte    <= '0;
      aq_valid   <= 1'b0;
      aq_byte    <= '0;
      kdev_valid <= 1'b0;
      kdev_byte  <= '0;
      mdev_valid <= 1'b0;
      mdev_byte  <= '0;
    end else begin
      sysrst_o   <= 1'b0;
      kq_valid   <= 1'b0;
      aq_valid   <= 1'b0;
      kdev_valid <= 1'b0;
      mdev_valid <= 1'b0;
      if (cmd_wr) begin
        if (pulse_range) begin
          sysrst_o <= ~wr_byte[0];
        end else begin
          case (wr_byte)
            8'h20: begin kq_valid <= 1'b1; kq_byte <= mode_q; end
            8'hD0: begin kq_valid <= 1'b1; kq_byte <= port_q; end
            8'h60, 8'hD1, 8'hD2, 8'hD3, 8'hD4: latch_q <= wr_byte;
            8'hA7: mode_q[5] <= 1'b1;
            8'hA8: mode_q[5] <= 1'b0;
            8'hAD: mode_q[4] <= 1'b1;
            8'hAE: mode_q[4] <= 1'b0;
            8'hA9, 8'hAB, 8'hC0: begin kq_valid <= 1'b1; kq_byte <= '0; end
            8'hAA: begin
              stat_q[2] <= 1'b1;
              kq_valid  <= 1'b1;
              kq_byte   <= BW'(8'h55);
            end
            8'hDF: port_q[1] <= 1'b1;
            8'hDD: port_q[1] <= 1'b0;
            default: ;
          endcase
        end
      end
      if (data_wr) begin
        latch_q <= IDLE;
        case (latch_q)
          8'h60: mode_q <= wr_byte;
          8'hD1: begin port_q <= wr_byte; sysrst_o <= ~wr_byte[0]; end
          8'hD2: begin kq_valid <= 1'b1; kq_byte <= wr_byte; end
          8'hD3: begin aq_valid <= 1'b1; aq_byte <= wr_byte; end
          8'hD4: begin mdev_valid <= 1'b1; mdev_byte <= wr_byte; end
          default: begin kdev_valid <= 1'b1; kdev_byte <= wr_byte; end
        endcase
      end
    end
  end
endmodule

// File: rtl/ps2_host_cmd_chk.sv
module ps2_host_cmd_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       wr_is_cmd,
  input logic [7:0] wr_byte,
  input logic [7:0] status_o,
  input logic       a20_o,
  input logic       xlate_o,
  input logic       sysrst_o,
  input logic       kq_valid,
  input logic [7:0] kq_byte,
  input logic       aq_valid,
  input logic [7:0] aq_byte,
  input logic       kdev_valid,
  input logic [7:0] kdev_byte,
  input logic       mdev_valid,
  input logic [7:0] mdev_byte
);
  assert_a20_on_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_is_cmd && wr_byte == 8'hDF |=> a20_o);
  assert_a20_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_is_cmd && wr_byte == 8'hDD |=> !a20_o);
  assert_pulse_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_is_cmd && wr_byte[7:4] == 4'hF && !wr_byte[0] |=> sysrst_o);
  assert_pulse_noop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_is_cmd && wr_byte[7:4] == 4'hF && wr_byte[0] |=> !sysrst_o);
  assert_selftest_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_is_cmd && wr_byte == 8'hAA |=> kq_valid && kq_byte == 8'h55 && status_o[2]);
  assert_one_push_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({kq_valid, aq_valid, kdev_valid, mdev_valid}));
  assert_quiet_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> !(kq_valid || aq_valid || kdev_valid || mdev_valid || sysrst_o)
               && $stable(status_o) && $stable(a20_o) && $stable(xlate_o));
  assert_unknown_cmd_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_is_cmd && (wr_byte == 8'h00 || wr_byte == 8'h55 || wr_byte == 8'hB3)
    |=> !(kq_valid || aq_valid || kdev_valid || mdev_valid || sysrst_o)
        && $stable(status_o) && $stable(a20_o) && $stable(xlate_o));
endmodule

bind ps2_host_cmd ps2_host_cmd_chk u_chk (.*);

// File: tb/sim_ps2_host_cmd.sv
module sim_ps2_host_cmd;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, wr_is_cmd = 1'b0;
  logic [7:0] wr_byte = 8'h00;
  logic [7:0] status_o, kq_byte, aq_byte, kdev_byte, mdev_byte;
  logic a20_o, xlate_o, sysrst_o, kq_valid, aq_valid, kdev_valid, mdev_valid;

  always #5 clk = ~clk;

  ps2_host_cmd u0 (.*);

  int vectors = 0, miscompares = 0, cycles = 0;
  string cur_req = "R1", req_q = "R1";

  // behavioural reference
  int m_mode, m_stat, m_port, m_latch;
  bit e_rst, e_kq, e_aq, e_kd, e_md;
  int e_kqb, e_aqb, e_kdb, e_mdb;

  always @(posedge clk) begin
    req_q = cur_req;
    e_rst = 0; e_kq = 0; e_aq = 0; e_kd = 0; e_md = 0;
    if (!rst_n) begin
      m_mode = 3; m_stat = 'h18; m_port = 3; m_latch = 0;
      e_kqb = 0; e_aqb = 0; e_kdb = 0; e_mdb = 0;
    end else if (wr_en && wr_is_cmd) begin
      if (wr_byte >= 8'hF0) e_rst = (wr_byte % 2 == 0);
      else if (wr_byte == 8'h20) begin e_kq = 1; e_kqb = m_mode; end
      else if (wr_byte == 8'hD0) begin e_kq = 1; e_kqb = m_port; end
      else if (wr_byte == 8'h60 || (wr_byte >= 8'hD1 && wr_byte <= 8'hD4)) m_latch = wr_byte;
      else if (wr_byte == 8'hA7) m_mode = m_mode | 32;
      else if (wr_byte == 8'hA8) m_mode = m_mode & ~32;
      else if (wr_byte == 8'hAD) m_mode = m_mode | 16;
      else if (wr_byte == 8'hAE) m_mode = m_mode & ~16;
      else if (wr_byte == 8'hAA) begin m_stat = m_stat | 4; e_kq = 1; e_kqb = 'h55; end
      else if (wr_byte == 8'hA9 || wr_byte == 8'hAB || wr_byte == 8'hC0) begin e_kq = 1; e_kqb = 0; end
      else if (wr_byte == 8'hDF) m_port = m_port | 2;
      else if (wr_byte == 8'hDD) m_port = m_port & ~2;
    end else if (wr_en) begin
      case (m_latch)
        'h60: m_mode = wr_byte;
        'hD1: begin m_port = wr_byte; e_rst = (wr_byte % 2 == 0); end
        'hD2: begin e_kq = 1; e_kqb = wr_byte; end
        'hD3: begin e_aq = 1; e_aqb = wr_byte; end
        'hD4: begin e_md = 1; e_mdb = wr_byte; end
        default: begin e_kd = 1; e_kdb = wr_byte; end
      endcase
      m_latch = 0;
    end
  end

  task automatic cmp(string what, int act, int exp);
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h", req_q, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    vectors++;
    cmp("status", status_o, m_stat);
    cmp("a20", a20_o, (m_port >> 1) & 1);
    cmp("xlate", xlate_o, (m_mode >> 6) & 1);
    cmp("sysrst", sysrst_o, e_rst);
    cmp("kq_valid", kq_valid, e_kq);
    cmp("aq_valid", aq_valid, e_aq);
    cmp("kdev_valid", kdev_valid, e_kd);
    cmp("mdev_valid", mdev_valid, e_md);
    if (e_kq) cmp("kq_byte", kq_byte, e_kqb);
    if (e_aq) cmp("aq_byte", aq_byte, e_aqb);
    if (e_kd) cmp("kdev_byte", kdev_byte, e_kdb);
    if (e_md) cmp("mdev_byte", mdev_byte, e_mdb);
  end

  task automatic wr(bit is_cmd, logic [7:0] b, string req);
    @(negedge clk);
    cur_req = req; wr_en = 1; wr_is_cmd = is_cmd; wr_byte = b;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic wr_b2b(logic [7:0] b, string req);
    @(negedge clk);
    cur_req = req; wr_en = 1; wr_is_cmd = 1; wr_byte = b;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    wr(1, 8'h20, "R1"); wr(1, 8'hD0, "R1");
    wr(0, 8'h1C, "R3");
    wr(1, 8'h60, "R2"); wr(0, 8'h43, "R10");
    wr(1, 8'h20, "R4");
    wr(0, 8'h11, "R2");
    wr(1, 8'h60, "R10"); wr(0, 8'h03, "R10");
    wr(1, 8'hD2, "R2"); wr(0, 8'hAB, "R2");
    wr(1, 8'hD3, "R2"); wr(0, 8'h5A, "R2");
    wr(1, 8'hD4, "R2"); wr(0, 8'hE8, "R2");
    wr(0, 8'hF4, "R3");
    wr(1, 8'hAA, "R5"); wr(1, 8'hA9, "R5"); wr(1, 8'hAB, "R5"); wr(1, 8'hC0, "R5");
    wr(1, 8'hA7, "R6"); wr(1, 8'h20, "R6"); wr(1, 8'hA8, "R6");
    wr(1, 8'hAD, "R6"); wr(1, 8'h20, "R6"); wr(1, 8'hAE, "R6"); wr(1, 8'h20, "R6");
    wr(1, 8'hDD, "R7"); wr(1, 8'hD0, "R7"); wr(1, 8'hDF, "R7"); wr(1, 8'hD0, "R7");
    wr(1, 8'hF1, "R8"); wr(1, 8'hFF, "R8"); wr(1, 8'hFE, "R8");
    wr(1, 8'hF0, "R8"); wr(1, 8'hF6, "R8");
    wr(1, 8'hD1, "R9"); wr(0, 8'h00, "R9");
    wr(1, 8'hD0, "R9");
    wr(1, 8'hD1, "R9"); wr(0, 8'h01, "R9");
    wr(1, 8'hD1, "R9"); wr(0, 8'h02, "R9");
    wr(1, 8'hD1, "R9"); wr(0, 8'h03, "R9");
    wr(1, 8'hD0, "R9");
    wr(1, 8'h55, "R11"); wr(1, 8'h00, "R11"); wr(1, 8'hB3, "R11");
    wr(1, 8'h20, "R11");
    wr(1, 8'h60, "R11"); wr(1, 8'hA7, "R11"); wr(0, 8'h41, "R11");
    wr(1, 8'h20, "R11");
    wr(1, 8'hD1, "R11"); wr(1, 8'hFE, "R11"); wr(0, 8'h03, "R11");
    wr_b2b(8'hFE, "R12"); wr_b2b(8'hFE, "R12"); wr_b2b(8'h20, "R12");
    wr_b2b(8'hD0, "R12");
    @(negedge clk); wr_en = 0;
    repeat (4) @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      miscompares++;
      $display("FAIL watchdog: actual %0d expected below 5000 cycles", cycles);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule